// File: doc/BRIEF.md
# Masked Interrupt Flag and Enable Unit

This unit gathers the interrupt events of a small peripheral into one request line. Each of seven sources owns a pending flag and an enable bit. A one-cycle event pulse on a source sets its flag. The flag stays set until one of three things clears it: a dedicated clear strobe, a software write of a one to that flag position, or, for the shift-register source only, a software read of the shift data address. The request line is high whenever at least one flag is pending while its enable is set.

Software reaches the unit through single-cycle byte accesses. A write to the enable address uses the top data bit to choose the action: a one adds the written bits to the enable set, and a zero removes the written bits from it. A read of the flag address returns a summary bit in the top position. A read of the enable address always returns a one in that position. Source positions: bit 6 is the first timer, bit 5 is the second timer, and bit 2 is the shift register. The other positions are spare sources for port handshakes.

Top module: `irq_mask_unit`

## Requirements
- R1: `irqOut` is a register. At each rising edge it takes the OR over all bits of (stored flags AND stored enables) as they stood before that edge.
- R2: A write to the flag address (default 0x5) clears each flag whose data bit 6..0 is one. Flags written as zero keep their value.
- R3: A write to the enable address (default 0x6) with data bit 7 = 1 ORs data bits 6..0 into the enables.
- R4: A write to the enable address with data bit 7 = 0 clears each enable whose data bit 6..0 is one. The other enables keep their value.
- R5: A read of the flag address returns the flags on bits 6..0 in the same cycle. Bit 7 is one exactly when some flag and its enable are both set.
- R6: A read of the enable address returns bit 7 = 1 and the enables on bits 6..0.
- R7: A read of the shift data address (default 0x2) clears flag bit 2 and no other flag. The read returns 0x00.
- R8: A one on `clrEv[i]` clears flag i at the next edge.
- R9: A one on `setEv[i]` sets flag i at the next edge. A set wins over any clear of the same flag in the same cycle.
- R10: While reset is held and right after it, all flags and enables are zero and `irqOut` is low. The enable readback is therefore 0x80.
- R11: Reads of any other address return 0x00. Writes to other addresses, and reads of the flag or enable address, leave every flag and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdEn | input | 1 | Read strobe for the current cycle |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the same cycle as rdEn |
| setEv | input | 7 | Per-source event pulses that set flags |
| clrEv | input | 7 | Per-source clear strobes |
| irqOut | output | 1 | Registered active-high interrupt request |

## Verification
Read data is combinational. The bench samples it one nanosecond after driving the read, in the same cycle, and compares it with the model state left by the previous edge. Writes, strobes and events change the stored flags and enables at the next rising edge. The request line follows one edge after that, so a stimulus shows on `irqOut` two edges after it is driven. The model therefore updates its request bit from its own pre-edge state and compares it just after every edge. Flag and enable effects are observed by reading them back in a later cycle.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  // Default source positions inside the flag and enable registers
  localparam int SRC_TIMER_A = 6;
  localparam int SRC_TIMER_B = 5;
  localparam int SRC_SHIFT   = 2;

  // Decoded access strobes handed from control to datapath
  typedef struct packed {
    logic flagWr;
    logic enWr;
    logic flagRd;
    logic enRd;
    logic shiftRd;
  } accessStrobes_t;

endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int              ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 4'h5,
  parameter logic [ADDR_W-1:0] EN_ADDR    = 4'h6,
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = 4'h2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output accessStrobes_t    strobes
);

  logic hitFlag;
  logic hitEn;
  logic hitShift;

  always_comb begin
    hitFlag  = (addr == FLAG_ADDR);
    hitEn    = (addr == EN_ADDR);
    hitShift = (addr == SHIFT_ADDR);

    strobes.flagWr  = wrEn & hitFlag;
    strobes.enWr    = wrEn & hitEn;
    strobes.flagRd  = rdEn & hitFlag;
    strobes.enRd    = rdEn & hitEn;
    strobes.shiftRd = rdEn & hitShift;
  end

endmodule

// File: rtl/irq_mask_dp.sv
module irq_mask_dp
  import irq_mask_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHIFT_BIT = SRC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobes_t    strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-2:0] setEv,
  input  logic [DATA_W-2:0] clrEv,
  output logic [DATA_W-2:0] flagQ,
  output logic [DATA_W-2:0] enQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int NUM_SRC = DATA_W - 1;
  localparam int MODE_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] swClear;
  logic [NUM_SRC-1:0] readClear;
  logic [NUM_SRC-1:0] flagD;
  logic [NUM_SRC-1:0] enD;
  logic               pending;

  always_comb begin
    swClear   = strobes.flagWr ? wrData[NUM_SRC-1:0] : '0;
    readClear = '0;
    if (strobes.shiftRd) readClear[SHIFT_BIT] = 1'b1;
  end

  // One flag cell per source: set dominates every clear path
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb begin
      if (setEv[i])
        flagD[i] = 1'b1;
      else if (clrEv[i] | swClear[i] | readClear[i])
        flagD[i] = 1'b0;
      else
        flagD[i] = flagQ[i];
    end
  end

  always_comb begin
    enD = enQ;
    if (strobes.enWr) begin
      if (wrData[MODE_BIT])
        enD = enQ | wrData[NUM_SRC-1:0];
      else
        enD = enQ & ~wrData[NUM_SRC-1:0];
    end
  end

  assign pending = |(flagQ & enQ);

  always_comb begin
    if (strobes.flagRd)
      rdData = {pending, flagQ};
    else if (strobes.enRd)
      rdData = {1'b1, enQ};
    else
      rdData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      flagQ  <= flagD;
      enQ    <= enD;
      irqOut <= pending;
    end
  end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 4'h5,
  parameter logic [ADDR_W-1:0] EN_ADDR    = 4'h6,
  parameter logic [ADDR_W-1:0] SHIFT_ADDR = 4'h2,
  parameter int                SHIFT_BIT  = SRC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-2:0] setEv,
  input  logic [DATA_W-2:0] clrEv,
  output logic              irqOut
);

  accessStrobes_t    strobes;
  logic [DATA_W-2:0] flagQ;
  logic [DATA_W-2:0] enQ;

  irq_mask_ctrl #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .EN_ADDR   (EN_ADDR),
    .SHIFT_ADDR(SHIFT_ADDR)
  ) u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobes(strobes)
  );

  irq_mask_dp #(
    .DATA_W   (DATA_W),
    .SHIFT_BIT(SHIFT_BIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .setEv  (setEv),
    .clrEv  (clrEv),
    .flagQ  (flagQ),
    .enQ    (enQ),
    .rdData (rdData),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk #(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 4'h5,
  parameter logic [ADDR_W-1:0] EN_ADDR    = 4'h6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-2:0] setEv,
  input logic [DATA_W-2:0] flagQ,
  input logic [DATA_W-2:0] enQ,
  input logic              irqOut
);

  assert_irq_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(flagQ & enQ))));

  assert_flag_write_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == FLAG_ADDR) |=>
      ((flagQ & $past(wrData[DATA_W-2:0]) & ~$past(setEv)) == '0));

  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == EN_ADDR && wrData[DATA_W-1]) |=>
      ((enQ & $past(wrData[DATA_W-2:0])) == $past(wrData[DATA_W-2:0])));

  assert_enable_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == EN_ADDR && !wrData[DATA_W-1]) |=>
      ((enQ & $past(wrData[DATA_W-2:0])) == '0));

  assert_enable_readback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == EN_ADDR) |-> (rdData == {1'b1, enQ}));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (setEv != '0) |=> ((flagQ & $past(setEv)) == $past(setEv)));

endmodule

bind irq_mask_unit irq_mask_unit_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .FLAG_ADDR(FLAG_ADDR),
  .EN_ADDR  (EN_ADDR)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .wrData(wrData),
  .rdData(rdData),
  .setEv (setEv),
  .flagQ (flagQ),
  .enQ   (enQ),
  .irqOut(irqOut)
);

// File: tb/irq_mask_unit_test.sv
module irq_mask_unit_test;

  localparam logic [3:0] A_FLAG  = 4'h5;
  localparam logic [3:0] A_EN    = 4'h6;
  localparam logic [3:0] A_SHIFT = 4'h2;
  localparam logic [3:0] A_OTHER = 4'h9;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, rdEn;
  logic [3:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic [6:0] setEv, clrEv;
  logic       irqOut;

  int nChecks = 0;
  int nErrors = 0;

  // Behavioural reference state
  logic [6:0] fM = '0;
  logic [6:0] eM = '0;
  logic       irqM = 1'b0;

  always #4 clk = ~clk;

  irq_mask_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .setEv(setEv), .clrEv(clrEv),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    if (a == A_FLAG) return {|(fM & eM), fM};
    if (a == A_EN)   return {1'b1, eM};
    return 8'h00;
  endfunction

  // One bus cycle: drive at negedge, check read data, step model at edge, check irq
  task automatic cyc(input logic we, input logic re, input logic [3:0] a,
                     input logic [7:0] d, input logic [6:0] s, input logic [6:0] c,
                     input string tag);
    logic [6:0] clr;
    wrEn = we; rdEn = re; addr = a; wrData = d; setEv = s; clrEv = c;
    #1;
    if (re) check(tag, rdData, modelRead(a));
    @(posedge clk);
    clr = c;
    if (we && a == A_FLAG)  clr = clr | d[6:0];
    if (re && a == A_SHIFT) clr = clr | 7'b0000100;
    irqM = |(fM & eM);
    fM = (fM & ~clr) | s;
    if (we && a == A_EN) eM = d[7] ? (eM | d[6:0]) : (eM & ~d[6:0]);
    #1;
    check("R1", {7'b0, irqOut}, {7'b0, irqM});
    @(negedge clk);
    wrEn = 0; rdEn = 0; setEv = '0; clrEv = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00, '0, '0, tag);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nErrors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    rstN = 0; wrEn = 0; rdEn = 0; addr = '0; wrData = '0; setEv = '0; clrEv = '0;
    repeat (3) @(negedge clk);
    check("R10", {7'b0, irqOut}, 8'h00);
    rstN = 1;
    // R10: reset values
    rd(A_FLAG, "R10");
    rd(A_EN, "R10");
    // R9: event sets first-timer flag (bit 6), not enabled yet
    cyc(0, 0, A_OTHER, 8'h00, 7'b1000000, '0, "R9");
    rd(A_FLAG, "R9");
    // R3: enable bit 6 with mode bit set
    cyc(1, 0, A_EN, 8'hC0, '0, '0, "R3");
    rd(A_EN, "R3");
    rd(A_FLAG, "R5");
    // R2: flags 5 and 2 set, write 0x20 clears only bit 5
    cyc(0, 0, A_OTHER, 8'h00, 7'b0100100, '0, "R9");
    cyc(1, 0, A_FLAG, 8'h20, '0, '0, "R2");
    rd(A_FLAG, "R2");
    // R4: clear enable of bit 6, other enables kept
    cyc(1, 0, A_EN, 8'h84, '0, '0, "R3");
    cyc(1, 0, A_EN, 8'h40, '0, '0, "R4");
    rd(A_EN, "R4");
    rd(A_FLAG, "R5");
    // R8: clear strobe on bit 6
    cyc(0, 0, A_OTHER, 8'h00, '0, 7'b1000000, "R8");
    rd(A_FLAG, "R8");
    // R7: shift-data read clears bit 2 only and returns zero
    cyc(0, 0, A_OTHER, 8'h00, 7'b0000011, '0, "R9");
    rd(A_SHIFT, "R7");
    rd(A_FLAG, "R7");
    // R9: set and clear together on bit 4, plus flag write on bit 4
    cyc(1, 0, A_FLAG, 8'h10, 7'b0010000, 7'b0010000, "R9");
    rd(A_FLAG, "R9");
    // R11: foreign address accesses touch nothing
    cyc(1, 0, A_OTHER, 8'hFF, '0, '0, "R11");
    rd(A_OTHER, "R11");
    rd(A_FLAG, "R11");
    rd(A_EN, "R11");
    // Mixed traffic compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      int op;
      op = $urandom_range(0, 3);
      case ($urandom_range(0, 3))
        0: a = A_FLAG;
        1: a = A_EN;
        2: a = A_SHIFT;
        default: a = A_OTHER;
      endcase
      cyc(op == 1, op == 2, a, 8'($urandom),
          7'($urandom) & 7'($urandom), 7'($urandom) & 7'($urandom) & 7'($urandom),
          "R1");
    end
    finishRun();
  end

endmodule